// File: doc/BRIEF.md
# Touch Sample Group Filter

This block turns groups of packed touch-panel samples into coordinate reports. When the sample FIFO asks for service, the block runs one pass. It pops up to four words over a valid/ready interface and stops early if the FIFO runs empty. It then emits one report: either a touch at an averaged, inverted position, or a pen release.

Each raw coordinate is inverted against full scale. Only the two middle samples of the group are averaged, because the first and last readings of a group are the ones most disturbed by panel settling. A touch counts only if the group was complete and its final sample still shows the pen down. If the FIFO flags an overrun when a pass begins, the block empties the FIFO and reports nothing.

Top module: `touch_group_filter`

## Requirements
- R1: A FIFO word carries the raw X coordinate in bits 25:16, the raw Y coordinate in bits 9:0, and the pen level in bit 31. A 1 in bit 31 means the pen is lifted.
- R2: Each reported coordinate is 1023 minus the raw 10-bit field.
- R3: A pass pops at most four words. It ends early when `fifoEmpty` is high, leaving any further words in the FIFO.
- R4: `reportTouch` is 1 only when four words were popped and the fourth has bit 31 at 0. Every other non-overrun pass gives a report with `reportTouch` at 0.
- R5: On a touch report, X and Y are each (a + b) / 2, truncated, where a and b are the inverted values from the second and third popped words. The sum is held in 11 bits, so two full-scale values give 1023.
- R6: If `fifoOverrun` is high in the cycle a pass starts, the block pops words until `fifoEmpty` and issues no report for that pass.
- R7: A pass starts only on `passReq` while the block is idle.
- R8: `reportValid` is high for exactly one cycle per reporting pass. `reportTouch`, `reportX` and `reportY` hold their values between reports. A release report leaves X and Y unchanged.
- R9: While the synchronous active-high reset is asserted, the block returns to idle, with all report outputs at 0 and `fifoReady` at 0.
- R10: `fifoReady` is 0 outside a pass, and 0 whenever `fifoEmpty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| passReq | input | 1 | Service request from the FIFO (group ready or pen lifted) |
| fifoData | input | 32 | Head word of the sample FIFO |
| fifoValid | input | 1 | Head word is valid |
| fifoEmpty | input | 1 | FIFO empty flag |
| fifoOverrun | input | 1 | FIFO overrun flag |
| fifoReady | output | 1 | Pop request; a word is taken when this and fifoValid are both high |
| reportValid | output | 1 | Single-cycle report strobe |
| reportTouch | output | 1 | 1 = touch at reportX/reportY, 0 = pen release |
| reportX | output | 10 | Reported X coordinate |
| reportY | output | 10 | Reported Y coordinate |

## Verification
The bench builds the block with its default parameters: groups of four, 10-bit coordinates, averaging slots 1 and 2, and the pen flag at bit 31. With these values, raw zeros drive the 11-bit sum to its largest value, 2046. An odd sum exposes the truncation, and a fifth queued word shows that the pop limit holds. A behavioural FIFO queue in the bench predicts each report from the words queued at request time. Short groups, a pen lift on the last word, an empty pass, and an overrun drain show both the early stop and the silent drain.

// File: rtl/tgf_pkg.sv
package tgf_pkg;
  typedef struct packed {
    logic capture;
    logic finish;
    logic full;
  } tgfCtlT;
endpackage

// File: rtl/tgf_ctrl.sv
module tgf_ctrl
  import tgf_pkg::*;
#(
  parameter int GROUP  = 4,
  parameter int SLOT_W = $clog2(GROUP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              passReq,
  input  logic              fifoValid,
  input  logic              fifoEmpty,
  input  logic              fifoOverrun,
  output logic              fifoReady,
  output logic [SLOT_W-1:0] slot,
  output tgfCtlT            ctl
);
  localparam int CNT_W = $clog2(GROUP + 1);

  typedef enum logic [1:0] {S_IDLE, S_COLLECT, S_DRAIN} stateT;
  stateT            state;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    fifoReady = 1'b0;
    ctl       = '0;
    case (state)
      S_COLLECT: begin
        ctl.full    = (cnt == CNT_W'(GROUP));
        fifoReady   = !ctl.full && !fifoEmpty;
        ctl.capture = fifoReady && fifoValid;
        ctl.finish  = ctl.full || fifoEmpty;
      end
      S_DRAIN: fifoReady = !fifoEmpty;
      default: ;
    endcase
  end

  assign slot = cnt[SLOT_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        S_IDLE: if (passReq) begin
          cnt   <= '0;
          state <= fifoOverrun ? S_DRAIN : S_COLLECT;
        end
        S_COLLECT: begin
          if (ctl.capture) cnt <= cnt + 1'b1;
          if (ctl.finish)  state <= S_IDLE;
        end
        S_DRAIN: if (fifoEmpty) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_OVR_DRAIN: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && passReq && fifoOverrun) |=> (state == S_DRAIN)); // R6
  AST_EMPTY_NO_POP: assert property (@(posedge clk) disable iff (rst)
    fifoEmpty |-> !fifoReady); // R10
  AST_IDLE_NO_POP: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE) |-> !fifoReady); // R10
  AST_POP_LIMIT: assert property (@(posedge clk) disable iff (rst)
    ctl.capture |-> (cnt < CNT_W'(GROUP))); // R3
endmodule

// File: rtl/tgf_datapath.sv
module tgf_datapath
  import tgf_pkg::*;
#(
  parameter int GROUP   = 4,
  parameter int DATA_W  = 32,
  parameter int COORD_W = 10,
  parameter int X_LSB   = 16,
  parameter int Y_LSB   = 0,
  parameter int PEN_BIT = 31,
  parameter int AVG_A   = 1,
  parameter int AVG_B   = 2,
  parameter int SLOT_W  = $clog2(GROUP)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DATA_W-1:0]  fifoData,
  input  logic [SLOT_W-1:0]  slot,
  input  tgfCtlT             ctl,
  output logic               reportValid,
  output logic               reportTouch,
  output logic [COORD_W-1:0] reportX,
  output logic [COORD_W-1:0] reportY
);
  localparam logic [COORD_W-1:0] FULL_SCALE = {COORD_W{1'b1}};

  logic [COORD_W-1:0] xInv [GROUP];
  logic [COORD_W-1:0] yInv [GROUP];
  logic               penUp [GROUP];

  for (genvar g = 0; g < GROUP; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        xInv[g]  <= '0;
        yInv[g]  <= '0;
        penUp[g] <= 1'b1;
      end else if (ctl.capture && slot == SLOT_W'(g)) begin
        xInv[g]  <= FULL_SCALE - fifoData[X_LSB +: COORD_W];
        yInv[g]  <= FULL_SCALE - fifoData[Y_LSB +: COORD_W];
        penUp[g] <= fifoData[PEN_BIT];
      end
    end
  end

  logic [COORD_W:0] sumX, sumY;
  logic             touchNow;
  assign sumX     = {1'b0, xInv[AVG_A]} + {1'b0, xInv[AVG_B]};
  assign sumY     = {1'b0, yInv[AVG_A]} + {1'b0, yInv[AVG_B]};
  assign touchNow = ctl.full && !penUp[GROUP-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      reportValid <= 1'b0;
      reportTouch <= 1'b0;
      reportX     <= '0;
      reportY     <= '0;
    end else begin
      reportValid <= ctl.finish;
      if (ctl.finish) begin
        reportTouch <= touchNow;
        if (touchNow) begin
          reportX <= sumX[COORD_W:1];
          reportY <= sumY[COORD_W:1];
        end
      end
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    reportValid |=> !reportValid); // R8
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !reportValid |-> ($stable(reportX) && $stable(reportY) && $stable(reportTouch))); // R8
  AST_RELEASE_KEEPS_POS: assert property (@(posedge clk) disable iff (rst)
    (reportValid && !reportTouch) |-> ($stable(reportX) && $stable(reportY))); // R8
  AST_TOUCH_NEEDS_GROUP: assert property (@(posedge clk) disable iff (rst)
    (reportValid && reportTouch) |-> $past(ctl.full)); // R4
endmodule

// File: rtl/touch_group_filter.sv
module touch_group_filter
  import tgf_pkg::*;
#(
  parameter int GROUP   = 4,
  parameter int DATA_W  = 32,
  parameter int COORD_W = 10,
  parameter int X_LSB   = 16,
  parameter int Y_LSB   = 0,
  parameter int PEN_BIT = 31,
  parameter int AVG_A   = 1,
  parameter int AVG_B   = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               passReq,
  input  logic [DATA_W-1:0]  fifoData,
  input  logic               fifoValid,
  input  logic               fifoEmpty,
  input  logic               fifoOverrun,
  output logic               fifoReady,
  output logic               reportValid,
  output logic               reportTouch,
  output logic [COORD_W-1:0] reportX,
  output logic [COORD_W-1:0] reportY
);
  localparam int SLOT_W = $clog2(GROUP);

  tgfCtlT            ctl;
  logic [SLOT_W-1:0] slot;

  tgf_ctrl #(.GROUP(GROUP), .SLOT_W(SLOT_W)) ctrl_i (
    .clk(clk), .rst(rst), .passReq(passReq), .fifoValid(fifoValid),
    .fifoEmpty(fifoEmpty), .fifoOverrun(fifoOverrun), .fifoReady(fifoReady),
    .slot(slot), .ctl(ctl)
  );

  tgf_datapath #(
    .GROUP(GROUP), .DATA_W(DATA_W), .COORD_W(COORD_W), .X_LSB(X_LSB),
    .Y_LSB(Y_LSB), .PEN_BIT(PEN_BIT), .AVG_A(AVG_A), .AVG_B(AVG_B), .SLOT_W(SLOT_W)
  ) dp_i (
    .clk(clk), .rst(rst), .fifoData(fifoData), .slot(slot), .ctl(ctl),
    .reportValid(reportValid), .reportTouch(reportTouch),
    .reportX(reportX), .reportY(reportY)
  );
endmodule

// File: tb/touch_group_filter_tb_top.sv
module touch_group_filter_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic passReq = 1'b0;
  logic [31:0] fifoData = '0;
  logic fifoValid = 1'b0, fifoEmpty = 1'b1, fifoOverrun = 1'b0;
  logic fifoReady, reportValid, reportTouch;
  logic [9:0] reportX, reportY;

  always #5 clk = ~clk;

  touch_group_filter dut_i (
    .clk(clk), .rst(rst), .passReq(passReq), .fifoData(fifoData),
    .fifoValid(fifoValid), .fifoEmpty(fifoEmpty), .fifoOverrun(fifoOverrun),
    .fifoReady(fifoReady), .reportValid(reportValid), .reportTouch(reportTouch),
    .reportX(reportX), .reportY(reportY)
  );

  int errors = 0, checks = 0, cyc = 0;
  logic [31:0] q[$];
  bit popArm = 0, ovrFlag = 0, pending = 0;
  int pendTouch, pendX, pendY;
  int heldTouch = 0, heldX = 0, heldY = 0;
  string curTag = "R4";

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(bit pen, int x, int y);
    logic [31:0] w = '0;
    w[31] = pen; w[25:16] = x[9:0]; w[9:0] = y[9:0];
    return w;
  endfunction

  // one clock of the behavioural FIFO plus the report model
  task automatic step(bit req);
    @(negedge clk);
    if (popArm) void'(q.pop_front());
    passReq     = req;
    fifoValid   = (q.size() != 0);
    fifoEmpty   = !fifoValid;
    fifoData    = fifoValid ? q[0] : 32'h0;
    fifoOverrun = ovrFlag && fifoValid;
    if (!fifoValid) ovrFlag = 0;
    #1;
    popArm = fifoReady && fifoValid;
    if (fifoEmpty) check(!fifoReady, "R10", "ready while empty", fifoReady, 0);
    if (reportValid) begin
      check(pending, "R8", "unexpected report strobe", 1, 0);
      if (pending) begin
        check(reportTouch == pendTouch, curTag, "touch flag", reportTouch, pendTouch);
        check(reportX == pendX, "R5", "X", reportX, pendX);
        check(reportY == pendY, "R5", "Y", reportY, pendY);
        heldTouch = pendTouch; heldX = pendX; heldY = pendY;
        pending = 0;
      end
    end else begin
      check(reportTouch == heldTouch && reportX == heldX && reportY == heldY,
            "R8", "held outputs", reportX, heldX);
    end
  endtask

  task automatic runPass(string tag, bit overrun, int expLeft);
    int n = (q.size() < 4) ? q.size() : 4;
    int xs[4], ys[4];
    bit penLast;
    for (int i = 0; i < n; i++) begin
      xs[i] = 1023 - int'(q[i][25:16]);
      ys[i] = 1023 - int'(q[i][9:0]);
    end
    penLast = (n > 0) ? q[n-1][31] : 1'b1;
    curTag  = tag;
    ovrFlag = overrun;
    if (!overrun) begin
      pending   = 1;
      pendTouch = (n == 4 && !penLast) ? 1 : 0;
      pendX     = pendTouch ? (xs[1] + xs[2]) / 2 : heldX;
      pendY     = pendTouch ? (ys[1] + ys[2]) / 2 : heldY;
    end
    step(1);
    for (int i = 0; i < 14; i++) step(0);
    check(!pending, tag, "report issued", pending, 0);
    check(q.size() == expLeft, overrun ? "R6" : "R3", "words left in FIFO", q.size(), expLeft);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 20000);
      $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(!reportValid && !reportTouch && reportX == 0 && reportY == 0 && !fifoReady,
          "R9", "reset outputs", reportX, 0);
    @(negedge clk); rst = 0;

    // R7/R10: queued words but no request -> nothing popped
    for (int i = 0; i < 4; i++) q.push_back(mk(0, 100 + i, 200 + i));
    for (int i = 0; i < 6; i++) step(0);
    check(q.size() == 4, "R7", "no pop without request", q.size(), 4);

    // R1 R2 R5: full group, pen down at the end
    runPass("R4", 0, 0);

    // R5: raw zeros -> maximum 11-bit sum, no overflow
    q.push_back(mk(0, 5, 5)); q.push_back(mk(0, 0, 0));
    q.push_back(mk(0, 0, 0)); q.push_back(mk(0, 9, 9));
    runPass("R5", 0, 0);

    // R5: odd sum truncates; R1 field positions with distinct X/Y
    q.push_back(mk(0, 1023, 0)); q.push_back(mk(0, 1022, 3));
    q.push_back(mk(0, 1019, 10)); q.push_back(mk(0, 7, 7));
    runPass("R1", 0, 0);

    // R4: pen lifted on fourth word -> release, X/Y held
    q.push_back(mk(0, 300, 300)); q.push_back(mk(0, 310, 320));
    q.push_back(mk(0, 330, 340)); q.push_back(mk(1, 350, 360));
    runPass("R4", 0, 0);

    // R2: touch at a new place so later releases prove holding
    q.push_back(mk(0, 0, 0)); q.push_back(mk(0, 523, 23));
    q.push_back(mk(0, 523, 23)); q.push_back(mk(0, 1, 1));
    runPass("R2", 0, 0);

    // R3: only three words -> early stop, release
    q.push_back(mk(0, 1, 2)); q.push_back(mk(0, 3, 4)); q.push_back(mk(0, 5, 6));
    runPass("R3", 0, 0);

    // R4: empty FIFO pass -> release
    runPass("R4", 0, 0);

    // R3: five words -> four popped, one left
    for (int i = 0; i < 5; i++) q.push_back(mk(0, 40 * i, 30 * i));
    runPass("R3", 0, 1);
    q.delete(); step(0);

    // R6: overrun -> drain everything, no report
    for (int i = 0; i < 6; i++) q.push_back(mk(0, 11 * i, 13 * i));
    runPass("R6", 1, 0);

    // R8: one more normal pass after the drain
    q.push_back(mk(0, 64, 64)); q.push_back(mk(0, 128, 256));
    q.push_back(mk(0, 129, 257)); q.push_back(mk(0, 64, 64));
    runPass("R8", 0, 0);

    // R9: reset mid-life returns outputs to zero
    @(negedge clk); rst = 1;
    @(negedge clk); #1;
    check(!reportValid && !reportTouch && reportX == 0 && reportY == 0,
          "R9", "outputs after reset", reportX, 0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule